// File: doc/BRIEF.md
# Slot-Based Power-Up Sequencer

This block switches on a group of power rail enables in a programmed order after a power-on request. Each rail is given a small slot number. Accepting the request counts as slot 0. The sequencer then moves through slots 1 to 8, one at a time, and asserts the enable of every rail whose slot has been reached. All timing is counted in ticks of a 32 kHz strobe, so the sequence never waits for any rail's voltage to come up.

The gap between slots comes from a 2-bit length code. The gap from slot 0 to slot 1 is two ticks longer than the later gaps at the longest setting. The length code and all slot assignments are captured when the request is accepted, so changes on those inputs during a sequence have no effect. Dropping the request clears every enable and returns the block to idle.

Top module: `pwr_slot_seq`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), all enables, the slot index and `done_o` are 0, and the captured length code is 11.
- R2: A clock edge in idle with `pwr_req_i` high accepts the request at slot 0. No enable is asserted, and ticks arriving in that same cycle are not counted.
- R3: The number of ticks between slots, for the slots after slot 1, is set by `slot_len_i`: 11 = 64, 10 = 16, 01 = 7, 00 = 1 (slots then advance on consecutive ticks).
- R4: The gap from slot 0 to slot 1 is 66 ticks for code 11. For the other codes it equals the later gaps.
- R5: The slot index only ever rises by exactly one and stops at 8. `done_o` is high exactly when the slot index is 8 and stays high while the request is held.
- R6: Rail r takes its slot value from `rail_slot_i[4r+3:4r]`. Its enable is high once the slot index is at least that value, when the value lies in 1..8. A value of 0 or above 8 never enables the rail. Rails that share a slot are enabled on the same tick.
- R7: The length code and the slot assignments are sampled when the request is accepted. Changes on those inputs are ignored until the block is back in idle.
- R8: A clock edge with `pwr_req_i` low clears every enable, the slot index and `done_o`, and returns the block to idle. A later request starts a fresh sequence.
- R9: The slot index changes only on a tick. Cycles without a tick leave all outputs unchanged.
- R10: While the request is held, no asserted enable is ever deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at the 32 kHz rate |
| pwr_req_i | input | 1 | Power-on request, level sensitive |
| slot_len_i | input | 2 | Slot length code |
| rail_slot_i | input | N_RAILS*4 | Packed slot number per rail |
| rail_en_o | output | N_RAILS | Rail enables |
| cur_slot_o | output | 4 | Current slot index |
| done_o | output | 1 | High once slot 8 is reached |

## Verification
The hardest case to reach from the ports is the capture rule. The slot inputs only matter at the moment of acceptance, so a wrong design that reads them live would still look correct whenever they stay constant. The bench therefore replaces the length code and every rail's slot with their bitwise inverses in the cycle after acceptance. It then sweeps every tick of complete sequences for all four codes, with two rail layouts, and checks each tick against slot arithmetic computed in the bench. A tick-free stall just after slot 1, an abort in the middle of a sequence and a restart cover the time-only progress rule and the return to idle.

// File: rtl/pwr_slot_seq_pkg.sv
package pwr_slot_seq_pkg;

  typedef enum logic [1:0] {
    LEN_ZERO  = 2'b00,
    LEN_SHORT = 2'b01,
    LEN_MID   = 2'b10,
    LEN_LONG  = 2'b11
  } slot_len_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned TICKS_LONG   = 64;
  localparam int unsigned TICKS_EXTRA  = 2;
  localparam int unsigned TICKS_MID    = 16;
  localparam int unsigned TICKS_SHORT  = 7;
  localparam int unsigned TICKS_MAXGAP = TICKS_LONG + TICKS_EXTRA;

  // zero-length gap still needs one tick to advance
  function automatic logic [7:0] gap_ticks(slot_len_e code, logic first);
    unique case (code)
      LEN_LONG:  gap_ticks = first ? 8'(TICKS_MAXGAP) : 8'(TICKS_LONG);
      LEN_MID:   gap_ticks = 8'(TICKS_MID);
      LEN_SHORT: gap_ticks = 8'(TICKS_SHORT);
      default:   gap_ticks = 8'd1;
    endcase
  endfunction

endpackage

// File: rtl/pwr_gap_timer.sv
module pwr_gap_timer
  import pwr_slot_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      first_i,
  input  logic      tick_i,
  input  slot_len_e code_i,
  output logic      step_o
);
  localparam int unsigned CNT_W = $clog2(TICKS_MAXGAP + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, target;

  assign target  = CNT_W'(gap_ticks(code_i, first_i));
  assign cnt_nxt = cnt_q + 1'b1;
  assign step_o  = run_i && tick_i && (cnt_nxt == target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || step_o)  cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_nxt;
  end

  AST_CNT_BELOW_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < target); // R3

endmodule

// File: rtl/pwr_slot_fsm.sv
module pwr_slot_fsm
  import pwr_slot_seq_pkg::*;
#(
  parameter int unsigned SLOT_W   = 4,
  parameter int unsigned MAX_SLOT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              step_i,
  output logic              load_o,
  output logic              run_o,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(MAX_SLOT);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_RUN;
        slot_d  = '0;
      end
      ST_RUN: begin
        if (!req_i) begin
          state_d = ST_IDLE;
          slot_d  = '0;
        end else if (step_i) begin
          slot_d = slot_q + 1'b1;
          if (slot_d == LAST) state_d = ST_DONE;
        end
      end
      default: if (!req_i) begin
        state_d = ST_IDLE;
        slot_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign load_o   = (state_q == ST_IDLE) && req_i;
  assign run_o    = (state_q == ST_RUN);
  assign active_o = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign slot_o   = slot_q;

  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST); // R5
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != $past(slot_q)) && (slot_q != '0) |-> slot_q == $past(slot_q) + 1'b1); // R5

endmodule

// File: rtl/pwr_rail_gate.sv
module pwr_rail_gate #(
  parameter int unsigned N_RAILS  = 6,
  parameter int unsigned SLOT_W   = 4,
  parameter int unsigned MAX_SLOT = 8
) (
  input  logic                      active_i,
  input  logic [SLOT_W-1:0]         cur_slot_i,
  input  logic [N_RAILS*SLOT_W-1:0] cfg_slot_i,
  output logic [N_RAILS-1:0]        en_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(MAX_SLOT);

  for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
    logic [SLOT_W-1:0] s;
    assign s       = cfg_slot_i[r*SLOT_W +: SLOT_W];
    assign en_o[r] = active_i && (s != '0) && (s <= LAST) && (s <= cur_slot_i);
  end

endmodule

// File: rtl/pwr_slot_seq.sv
module pwr_slot_seq
  import pwr_slot_seq_pkg::*;
#(
  parameter int unsigned N_RAILS  = 6,
  parameter int unsigned SLOT_W   = 4,
  parameter int unsigned MAX_SLOT = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      pwr_req_i,
  input  logic [1:0]                slot_len_i,
  input  logic [N_RAILS*SLOT_W-1:0] rail_slot_i,
  output logic [N_RAILS-1:0]        rail_en_o,
  output logic [SLOT_W-1:0]         cur_slot_o,
  output logic                      done_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(MAX_SLOT);

  slot_len_e                 len_q;
  logic [N_RAILS*SLOT_W-1:0] cfg_slot_q;
  logic                      load, run, active, step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= LEN_LONG;
      cfg_slot_q <= '0;
    end else if (load) begin
      len_q      <= slot_len_e'(slot_len_i);
      cfg_slot_q <= rail_slot_i;
    end
  end

  pwr_gap_timer u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .first_i (cur_slot_o == '0),
    .tick_i  (tick_i),
    .code_i  (len_q),
    .step_o  (step)
  );

  pwr_slot_fsm #(.SLOT_W(SLOT_W), .MAX_SLOT(MAX_SLOT)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (pwr_req_i),
    .step_i   (step),
    .load_o   (load),
    .run_o    (run),
    .active_o (active),
    .slot_o   (cur_slot_o),
    .done_o   (done_o)
  );

  pwr_rail_gate #(.N_RAILS(N_RAILS), .SLOT_W(SLOT_W), .MAX_SLOT(MAX_SLOT)) u_gate (
    .active_i   (active),
    .cur_slot_i (cur_slot_o),
    .cfg_slot_i (cfg_slot_q),
    .en_o       (rail_en_o)
  );

  AST_CLEAR_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_req_i |=> (rail_en_o == '0) && (cur_slot_o == '0) && !done_o); // R8
  AST_DONE_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cur_slot_o == LAST); // R5
  AST_EN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_req_i |=> (rail_en_o & $past(rail_en_o)) == $past(rail_en_o)); // R10
  AST_TICK_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_slot_o != $past(cur_slot_o)) && (cur_slot_o != '0) |-> $past(tick_i)); // R9

endmodule

// File: tb/sim_pwr_slot_seq.sv
module sim_pwr_slot_seq;
  localparam int N  = 6;
  localparam int SW = 4;

  logic          clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, req = 1'b0;
  logic [1:0]    len = 2'b00;
  logic [N*SW-1:0] slots = '0;
  logic [N-1:0]  en;
  logic [SW-1:0] cur;
  logic          done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwr_slot_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .pwr_req_i(req),
    .slot_len_i(len), .rail_slot_i(slots),
    .rail_en_o(en), .cur_slot_o(cur), .done_o(done)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gap(int c, bit first);
    case (c)
      3: return first ? 66 : 64;
      2: return 16;
      1: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_slot(int c, int k);
    int g1 = gap(c, 1'b1);
    int s;
    if (k < g1) return 0;
    s = 1 + (k - g1) / gap(c, 1'b0);
    return (s > 8) ? 8 : s;
  endfunction

  function automatic int exp_en(logic [N*SW-1:0] cfg, int s);
    int e = 0;
    for (int r = 0; r < N; r++) begin
      int v = int'(cfg[r*SW +: SW]);
      if (v != 0 && v <= 8 && v <= s) e |= (1 << r);
    end
    return e;
  endfunction

  task automatic check_at(input int c, input logic [N*SW-1:0] cfg, input int k);
    int es = exp_slot(c, k);
    chk((k <= gap(c, 1'b1)) ? "R4 slot" : "R3 slot", int'(cur), es);
    chk("R6 enables", int'(en), exp_en(cfg, es));
    chk("R5 done", int'(done), (es == 8) ? 1 : 0);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // accept, scramble live inputs, tick through; stop_at < 0 runs past the end
  task automatic run_seq(input int c, input logic [N*SW-1:0] cfg, input int stop_at);
    int kmax = gap(c, 1'b1) + 7 * gap(c, 1'b0) + 3;
    logic [N-1:0] prev;
    if (stop_at >= 0) kmax = stop_at;
    @(negedge clk);
    len = 2'(c); slots = cfg; req = 1'b1;
    tick = 1'b1;                 // tick in the accept cycle must be ignored
    @(negedge clk);
    tick = 1'b0;
    len = ~len; slots = ~slots;  // R7: changes after acceptance ignored
    chk("R2 slot at accept", int'(cur), 0);
    chk("R2 no enable at accept", int'(en), 0);
    prev = en;
    for (int k = 1; k <= kmax; k++) begin
      pulse_tick();
      check_at(c, cfg, k);
      chk("R10 enables held", int'(en & prev), int'(prev));
      prev = en;
      if (k == gap(c, 1'b1)) begin
        repeat (20) @(negedge clk);
        chk("R9 stall keeps slot", int'(cur), exp_slot(c, k));
      end
    end
    if (stop_at < 0) chk("R7 enables from captured config", int'(en), exp_en(cfg, 8));
  endtask

  task automatic drop_req();
    @(negedge clk) req = 1'b0;
    @(negedge clk);
    chk("R8 enables cleared", int'(en), 0);
    chk("R8 slot cleared", int'(cur), 0);
    chk("R8 done cleared", int'(done), 0);
  endtask

  localparam logic [N*SW-1:0] PAT_A = {4'd9, 4'd8, 4'd0, 4'd2, 4'd2, 4'd1};
  localparam logic [N*SW-1:0] PAT_B = {4'd1, 4'd4, 4'd5, 4'd5, 4'd7, 4'd3};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 enables in reset", int'(en), 0);
    chk("R1 slot in reset", int'(cur), 0);
    chk("R1 done in reset", int'(done), 0);
    @(negedge clk) rst_ni = 1'b1;

    for (int c = 0; c < 4; c++) begin
      run_seq(c, PAT_A, -1);
      drop_req();
      run_seq(c, PAT_B, -1);
      drop_req();
    end

    // abort mid-sequence, idle ticks, then a fresh start
    run_seq(1, PAT_B, 10);
    drop_req();
    for (int i = 0; i < 5; i++) pulse_tick();
    chk("R8 idle ticks keep slot", int'(cur), 0);
    chk("R8 idle ticks keep enables", int'(en), 0);
    run_seq(1, PAT_A, -1);
    drop_req();

    // reset in mid-sequence
    run_seq(2, PAT_A, 40);
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 enables after reset", int'(en), 0);
    chk("R1 slot after reset", int'(cur), 0);
    req = 1'b0;
    @(negedge clk) rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule